// File: doc/BRIEF.md
# Decimal Adjust Unit

This unit takes the raw binary outcome of an earlier add, subtract or multiply and turns it into decimal form. It can also get a two-digit unpacked dividend ready before a binary divide. Two encodings are handled. In packed BCD a byte holds two decimal digits. In unpacked or ASCII form a byte holds one digit in its low nibble. The caller presents a low byte, a high byte, the incoming carry and auxiliary-carry flags, and a 3-bit operation code. One clock later the unit returns the corrected bytes and flags.

The arithmetic that comes before the adjust is not part of this block. An execution pipeline is expected to feed it straight from its adder or multiplier and to write the registered result back to its accumulator and flags.

Top module: `dadj_unit`

## Requirements
- R1: A synchronous active-high reset drives lo_o, hi_o, cf_o and af_o to zero. Outside reset, each output reflects the inputs sampled at the previous rising clock edge, so the latency is one cycle.
- R2: Operation 0 is packed add adjust, low step. When lo_i[3:0] is above 9 or af_i is 1, the unit adds 06h and sets af_o. Otherwise af_o is 0. For operations 0 and 1, hi_o equals hi_i.
- R3: Operation 0, high step. When the original lo_i is above 99h or cf_i is 1, the unit adds 60h and sets cf_o. Otherwise cf_o is 0. Examples: 9Ah gives 00h with cf_o=1. 7Dh gives 83h with af_o=1 and cf_o=0.
- R4: Operation 1 is packed subtract adjust, low step. When lo_i[3:0] is above 9 or af_i is 1, the unit subtracts 06h and sets af_o. A borrow out of this step is treated as a carry in the high step.
- R5: Operation 1, high step. When the value after the low step is above 9Fh, or the carry is set (cf_i or the low-step borrow), the unit subtracts 60h and sets cf_o. Otherwise cf_o is 0. Examples: F9h with both flags set gives 93h with cf_o=1. 9Ah with both flags clear gives 94h with cf_o=0.
- R6: Operation 2 is ASCII add adjust. When lo_i[3:0] is above 9 or af_i is 1, the 16-bit value {hi_i,lo_i} is increased by 0106h and both cf_o and af_o are set. Otherwise both flags are cleared. In either case lo_o[7:4] is 0.
- R7: Operation 3 is ASCII subtract adjust. It uses the same condition as R6, but the 16-bit value is decreased by 0106h. Both flags follow the condition, and lo_o[7:4] is 0. Example: 00FFh gives FF09h with cf_o=1.
- R8: Operation 4 is multiply adjust. hi_o is lo_i divided by BASE and lo_o is lo_i modulo BASE. hi_i has no effect. cf_o and af_o equal cf_i and af_i.
- R9: Operation 5 is divide prepare. lo_o is (hi_i×BASE + lo_i) modulo 256 and hi_o is 0. cf_o and af_o equal cf_i and af_i.
- R10: Operations 6 and 7 are pass-through. All four outputs equal the corresponding inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (0..7, see R2–R10) |
| lo_i | input | 8 | Low byte of the raw result |
| hi_i | input | 8 | High byte of the raw result |
| cf_i | input | 1 | Incoming carry flag |
| af_i | input | 1 | Incoming auxiliary carry flag |
| lo_o | output | 8 | Adjusted low byte (registered) |
| hi_o | output | 8 | Adjusted high byte (registered) |
| cf_o | output | 1 | Adjusted carry flag (registered) |
| af_o | output | 1 | Adjusted auxiliary carry flag (registered) |

## Verification
The bench builds the unit with its default BASE of 10. With that value, the multiply and divide adjust vectors are ordinary decimal digit splits and merges. Those vectors include the 8-bit extremes: FFh splits into 19h and 05h, and FFh:FFh wraps to F5h. The packed vectors cover every path through the two-step correction: no correction, low step only, high step only, and both steps. They also include the subtract case where a low-step borrow alone forces the high step. The ASCII vectors include a low byte near FFh, so the carry out of the low byte into hi_o is observed directly.

// File: rtl/dadj_pkg.sv
package dadj_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PK_ADD = 3'd0,
    OP_PK_SUB = 3'd1,
    OP_UN_ADD = 3'd2,
    OP_UN_SUB = 3'd3,
    OP_UN_MUL = 3'd4,
    OP_UN_DIV = 3'd5,
    OP_HOLD_A = 3'd6,
    OP_HOLD_B = 3'd7
  } dadj_op_e;

  typedef struct packed {
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] hi;
    logic              cf;
    logic              af;
  } dadj_res_t;
endpackage

// File: rtl/dadj_packed.sv
// Two-step packed BCD correction; SUBTRACT selects the direction.
module dadj_packed
  import dadj_pkg::*;
#(
  parameter bit SUBTRACT = 1'b0
) (
  input  logic [BYTE_W-1:0] val_i,
  input  logic              cf_i,
  input  logic              af_i,
  output logic [BYTE_W-1:0] val_o,
  output logic              cf_o,
  output logic              af_o
);
  localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(9);
  localparam logic [BYTE_W:0]   LOW_FIX   = (BYTE_W+1)'(6);
  localparam logic [BYTE_W-1:0] HIGH_FIX  = BYTE_W'(8'h60);
  localparam logic [BYTE_W-1:0] ADD_LIM   = BYTE_W'(8'h99);
  localparam logic [BYTE_W-1:0] SUB_LIM   = BYTE_W'(8'h9F);

  logic              low_hit;
  logic              high_hit;
  logic [BYTE_W:0]   step1;
  logic [BYTE_W-1:0] mid;

  assign low_hit = (val_i[NIB_W-1:0] > DIGIT_MAX) | af_i;

  generate
    if (SUBTRACT) begin : g_sub
      logic cf_mid;
      assign step1    = {1'b0, val_i} - LOW_FIX;
      assign mid      = low_hit ? step1[BYTE_W-1:0] : val_i;
      // a borrow out of the low step counts as carry for the high step
      assign cf_mid   = cf_i | (low_hit & step1[BYTE_W]);
      assign high_hit = (mid > SUB_LIM) | cf_mid;
      assign val_o    = high_hit ? (mid - HIGH_FIX) : mid;
    end else begin : g_add
      assign step1    = {1'b0, val_i} + LOW_FIX;
      assign mid      = low_hit ? step1[BYTE_W-1:0] : val_i;
      // any low-step carry implies val_i > 99h, so the original test covers it
      assign high_hit = (val_i > ADD_LIM) | cf_i;
      assign val_o    = high_hit ? (mid + HIGH_FIX) : mid;
    end
  endgenerate

  assign cf_o = high_hit;
  assign af_o = low_hit;
endmodule

// File: rtl/dadj_ascii.sv
// Unpacked (one digit per byte) add/subtract correction over the 16-bit pair.
module dadj_ascii
  import dadj_pkg::*;
#(
  parameter bit SUBTRACT = 1'b0
) (
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic              af_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              flag_o
);
  localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(9);
  localparam logic [WORD_W-1:0] WORD_FIX  = WORD_W'(16'h0106);

  logic              hit;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] adj;
  logic [WORD_W-1:0] sel;

  assign hit  = (lo_i[NIB_W-1:0] > DIGIT_MAX) | af_i;
  assign word = {hi_i, lo_i};

  generate
    if (SUBTRACT) begin : g_sub
      assign adj = word - WORD_FIX;
    end else begin : g_add
      assign adj = word + WORD_FIX;
    end
  endgenerate

  assign sel    = hit ? adj : word;
  assign lo_o   = {{NIB_W{1'b0}}, sel[NIB_W-1:0]};
  assign hi_o   = sel[WORD_W-1:BYTE_W];
  assign flag_o = hit;
endmodule

// File: rtl/dadj_scale.sv
// Digit split after multiply and digit merge before divide, in radix BASE.
module dadj_scale
  import dadj_pkg::*;
#(
  parameter int BASE = 10
) (
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  output logic [BYTE_W-1:0] split_lo_o,
  output logic [BYTE_W-1:0] split_hi_o,
  output logic [BYTE_W-1:0] merge_lo_o
);
  localparam logic [BYTE_W-1:0] BASE_B = BYTE_W'(BASE);
  localparam logic [WORD_W-1:0] BASE_W = WORD_W'(BASE);

  logic [WORD_W-1:0] merged;

  assign split_hi_o = lo_i / BASE_B;
  assign split_lo_o = lo_i % BASE_B;
  assign merged     = ({{BYTE_W{1'b0}}, hi_i} * BASE_W) + {{BYTE_W{1'b0}}, lo_i};
  assign merge_lo_o = merged[BYTE_W-1:0];
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
  import dadj_pkg::*;
#(
  parameter int BASE = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic              cf_i,
  input  logic              af_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              cf_o,
  output logic              af_o
);
  localparam int N_PK = 2;

  // packed paths, index 0 = add, 1 = subtract
  logic [BYTE_W-1:0] pk_val [N_PK];
  logic              pk_cf  [N_PK];
  logic              pk_af  [N_PK];
  // unpacked paths, same indexing
  logic [BYTE_W-1:0] un_lo  [N_PK];
  logic [BYTE_W-1:0] un_hi  [N_PK];
  logic              un_flg [N_PK];

  logic [BYTE_W-1:0] sc_lo, sc_hi, mg_lo;
  dadj_res_t         nxt;
  dadj_res_t         res_q;

  generate
    for (genvar k = 0; k < N_PK; k++) begin : g_dir
      dadj_packed #(.SUBTRACT(k == 1)) u_pk (
        .val_i (lo_i),
        .cf_i  (cf_i),
        .af_i  (af_i),
        .val_o (pk_val[k]),
        .cf_o  (pk_cf[k]),
        .af_o  (pk_af[k])
      );
      dadj_ascii #(.SUBTRACT(k == 1)) u_un (
        .lo_i   (lo_i),
        .hi_i   (hi_i),
        .af_i   (af_i),
        .lo_o   (un_lo[k]),
        .hi_o   (un_hi[k]),
        .flag_o (un_flg[k])
      );
    end
  endgenerate

  dadj_scale #(.BASE(BASE)) u_scale (
    .lo_i       (lo_i),
    .hi_i       (hi_i),
    .split_lo_o (sc_lo),
    .split_hi_o (sc_hi),
    .merge_lo_o (mg_lo)
  );

  always_comb begin
    nxt = '{lo: lo_i, hi: hi_i, cf: cf_i, af: af_i};
    unique case (dadj_op_e'(op_i))
      OP_PK_ADD: nxt = '{lo: pk_val[0], hi: hi_i, cf: pk_cf[0], af: pk_af[0]};
      OP_PK_SUB: nxt = '{lo: pk_val[1], hi: hi_i, cf: pk_cf[1], af: pk_af[1]};
      OP_UN_ADD: nxt = '{lo: un_lo[0], hi: un_hi[0], cf: un_flg[0], af: un_flg[0]};
      OP_UN_SUB: nxt = '{lo: un_lo[1], hi: un_hi[1], cf: un_flg[1], af: un_flg[1]};
      OP_UN_MUL: nxt = '{lo: sc_lo, hi: sc_hi, cf: cf_i, af: af_i};
      OP_UN_DIV: nxt = '{lo: mg_lo, hi: '0, cf: cf_i, af: af_i};
      default:   nxt = '{lo: lo_i, hi: hi_i, cf: cf_i, af: af_i};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= nxt;
  end

  assign lo_o = res_q.lo;
  assign hi_o = res_q.hi;
  assign cf_o = res_q.cf;
  assign af_o = res_q.af;
endmodule

// File: rtl/dadj_unit_chk.sv
module dadj_unit_chk
  import dadj_pkg::*;
#(
  parameter int BASE = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op_i,
  input logic [BYTE_W-1:0] lo_i,
  input logic [BYTE_W-1:0] hi_i,
  input logic              cf_i,
  input logic              af_i,
  input logic [BYTE_W-1:0] lo_o,
  input logic [BYTE_W-1:0] hi_o,
  input logic              cf_o,
  input logic              af_o
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_padd_aux_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == OP_PK_ADD) |->
      (af_o == (($past(lo_i) & 8'h0F) > 8'h09 || $past(af_i)) && hi_o == $past(hi_i)));

  p_padd_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == OP_PK_ADD) |-> (cf_o == ($past(lo_i) > 8'h99 || $past(cf_i))));

  p_psub_carry_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == OP_PK_SUB && $past(cf_i)) |-> cf_o);

  p_ascii_add_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == OP_UN_ADD) |-> (lo_o[7:4] == 4'h0 && cf_o == af_o));

  p_ascii_sub_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == OP_UN_SUB) |-> (lo_o[7:4] == 4'h0 && cf_o == af_o));

  p_mul_digit_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == OP_UN_MUL) |->
      (int'(lo_o) < BASE && cf_o == $past(cf_i) && af_o == $past(af_i)));

  p_div_high_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) == OP_UN_DIV) |-> (hi_o == 8'h00 && cf_o == $past(cf_i)));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op_i) >= OP_HOLD_A) |->
      (lo_o == $past(lo_i) && hi_o == $past(hi_i) && cf_o == $past(cf_i) && af_o == $past(af_i)));
endmodule

bind dadj_unit dadj_unit_chk #(.BASE(BASE)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .lo_i(lo_i), .hi_i(hi_i), .cf_i(cf_i), .af_i(af_i),
  .lo_o(lo_o), .hi_o(hi_o), .cf_o(cf_o), .af_o(af_o)
);

// File: tb/tb_dadj_unit.sv
`timescale 1ns/1ps
module tb_dadj_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_i = 3'd0;
  logic [7:0] lo_i = 8'h00, hi_i = 8'h00;
  logic       cf_i = 1'b0, af_i = 1'b0;
  logic [7:0] lo_o, hi_o;
  logic       cf_o, af_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dadj_unit #(.BASE(10)) dut (
    .clk(clk), .rst(rst), .op_i(op_i), .lo_i(lo_i), .hi_i(hi_i), .cf_i(cf_i), .af_i(af_i),
    .lo_o(lo_o), .hi_o(hi_o), .cf_o(cf_o), .af_o(af_o)
  );

  task automatic expect_out(input string req, input logic [7:0] elo, input logic [7:0] ehi,
                            input logic ecf, input logic eaf);
    checks++;
    if (lo_o !== elo || hi_o !== ehi || cf_o !== ecf || af_o !== eaf) begin
      errors++;
      $display("FAIL %s: got lo=%h hi=%h cf=%b af=%b, expected lo=%h hi=%h cf=%b af=%b",
               req, lo_o, hi_o, cf_o, af_o, elo, ehi, ecf, eaf);
    end
  endtask

  // drive on a falling edge, result is registered at the next rising edge,
  // sampled at the falling edge after it
  task automatic run_vec(input string req, input logic [2:0] op, input logic [7:0] lo,
                         input logic [7:0] hi, input logic cf, input logic af,
                         input logic [7:0] elo, input logic [7:0] ehi,
                         input logic ecf, input logic eaf);
    @(negedge clk);
    op_i = op; lo_i = lo; hi_i = hi; cf_i = cf; af_i = af;
    @(negedge clk);
    expect_out(req, elo, ehi, ecf, eaf);
  endtask

  task automatic t_reset_r1();
    @(negedge clk);
    op_i = 3'd6; lo_i = 8'hA5; hi_i = 8'h5A; cf_i = 1'b1; af_i = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    expect_out("R1", 8'h00, 8'h00, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R1", 8'hA5, 8'h5A, 1'b1, 1'b1);
  endtask

  task automatic t_packed_add();
    run_vec("R2", 3'd0, 8'h7D, 8'h11, 1'b0, 1'b0, 8'h83, 8'h11, 1'b0, 1'b1);
    run_vec("R2", 3'd0, 8'h92, 8'h00, 1'b0, 1'b1, 8'h98, 8'h00, 1'b0, 1'b1);
    run_vec("R2", 3'd0, 8'h12, 8'h00, 1'b0, 1'b0, 8'h12, 8'h00, 1'b0, 1'b0);
    run_vec("R3", 3'd0, 8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1);
    run_vec("R3", 3'd0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h60, 8'h00, 1'b1, 1'b0);
    run_vec("R3", 3'd0, 8'hA5, 8'h00, 1'b0, 1'b0, 8'h05, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_packed_sub();
    run_vec("R4", 3'd1, 8'h3D, 8'h22, 1'b0, 1'b1, 8'h37, 8'h22, 1'b0, 1'b1);
    run_vec("R4", 3'd1, 8'h13, 8'h00, 1'b0, 1'b0, 8'h13, 8'h00, 1'b0, 1'b0);
    run_vec("R4", 3'd1, 8'h03, 8'h00, 1'b0, 1'b1, 8'h9D, 8'h00, 1'b1, 1'b1);
    run_vec("R5", 3'd1, 8'hF9, 8'h00, 1'b1, 1'b1, 8'h93, 8'h00, 1'b1, 1'b1);
    run_vec("R5", 3'd1, 8'hE9, 8'h00, 1'b1, 1'b1, 8'h83, 8'h00, 1'b1, 1'b1);
    run_vec("R5", 3'd1, 8'h9A, 8'h00, 1'b0, 1'b0, 8'h94, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_ascii_add_r6();
    run_vec("R6", 3'd2, 8'h6A, 8'h00, 1'b0, 1'b0, 8'h00, 8'h01, 1'b1, 1'b1);
    run_vec("R6", 3'd2, 8'h72, 8'h00, 1'b0, 1'b1, 8'h08, 8'h01, 1'b1, 1'b1);
    run_vec("R6", 3'd2, 8'hFA, 8'h05, 1'b0, 1'b0, 8'h00, 8'h07, 1'b1, 1'b1);
    run_vec("R6", 3'd2, 8'h37, 8'h00, 1'b1, 1'b0, 8'h07, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_ascii_sub_r7();
    run_vec("R7", 3'd3, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h09, 8'hFF, 1'b1, 1'b1);
    run_vec("R7", 3'd3, 8'h03, 8'h04, 1'b0, 1'b1, 8'h0D, 8'h02, 1'b1, 1'b1);
    run_vec("R7", 3'd3, 8'h34, 8'h05, 1'b1, 1'b0, 8'h04, 8'h05, 1'b0, 1'b0);
  endtask

  task automatic t_mul_r8();
    run_vec("R8", 3'd4, 8'h1E, 8'h77, 1'b1, 1'b0, 8'h00, 8'h03, 1'b1, 1'b0);
    run_vec("R8", 3'd4, 8'h41, 8'h00, 1'b0, 1'b1, 8'h05, 8'h06, 1'b0, 1'b1);
    run_vec("R8", 3'd4, 8'hFF, 8'hAA, 1'b0, 1'b0, 8'h05, 8'h19, 1'b0, 1'b0);
    run_vec("R8", 3'd4, 8'h09, 8'h00, 1'b0, 1'b0, 8'h09, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_div_r9();
    run_vec("R9", 3'd5, 8'h07, 8'h03, 1'b0, 1'b0, 8'h25, 8'h00, 1'b0, 1'b0);
    run_vec("R9", 3'd5, 8'h09, 8'h09, 1'b1, 1'b0, 8'h63, 8'h00, 1'b1, 1'b0);
    run_vec("R9", 3'd5, 8'hFF, 8'hFF, 1'b0, 1'b1, 8'hF5, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_hold_r10();
    run_vec("R10", 3'd6, 8'h5A, 8'hC3, 1'b1, 1'b0, 8'h5A, 8'hC3, 1'b1, 1'b0);
    run_vec("R10", 3'd7, 8'hFF, 8'h0F, 1'b0, 1'b1, 8'hFF, 8'h0F, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1", 8'h00, 8'h00, 1'b0, 1'b0);
    rst = 1'b0;
    t_packed_add();
    t_packed_sub();
    t_ascii_add_r6();
    t_ascii_sub_r7();
    t_mul_r8();
    t_div_r9();
    t_hold_r10();
    t_reset_r1();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected finish before timeout");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule